// File: doc/BRIEF.md
# Access Fault Status Capture Unit

This block sits beside the memory access stream of a simple fetch and load/store front end. Every access arrives with its own logical address, the start address of the transfer it belongs to, the address of the opword of the current instruction, an access kind, a sequence index inside a misaligned transfer, lock information, direction, size, transfer type and modifier, and a vector of fault causes. An access whose cause vector is nonzero is a faulting access.

On the first faulting access the unit latches two things. The first is a fault address, chosen so that the exception handler can restart the instruction or operand. The second is a 32-bit status word that records which access of the instruction or operand faulted, the lock state, the qualifiers of the access and the causes. A valid flag then holds both values steady until a clear pulse releases them. Later faults are dropped while the flag is set.

Top module: `fault_capture_unit`

## Requirements
- R1: When `accValid` is 1 and `cause` is nonzero while `faultValid` is 0, `faultValid` becomes 1 after the next rising edge. An access with `accValid` 0, or with `cause` all zero, captures nothing.
- R2: The access kind is encoded 00 for a data operand, 01 for an opword fetch and 10 for an extension word fetch, and 11 is treated as data. Status bit 27 is the instruction flag and bit 25 is the later-access flag. Together {27,25} read 00 for data at sequence index 0, 01 for data at index 1 or more, 10 for an opword fetch and 11 for an extension word fetch.
- R3: For a data fault at sequence index 0, the captured address is `accAddr`. At any index of 1 or more, it is `xferStart`.
- R4: For an opword fetch fault, the captured address is `accAddr`. For an extension word fault, it is `opwordAddr`.
- R5: Status bit 24 is `accLocked` OR `busLockMode`.
- R6: Status bit 23 is `accWrite` (1 means write). Bits 22:21 hold `accSize`, bits 20:19 hold `accType` and bits 18:16 hold `accMod`.
- R7: `cause[14:1]` is copied unchanged to status bits 15:2, and `cause[0]` is copied to bit 0. Any number of causes may be set together.
- R8: Status bits 31:28, 26 and 1 always read 0.
- R9: While `faultValid` is 1 and `clr` is 0, the captured address and status stay unchanged, whatever faults arrive.
- R10: A `clr` pulse zeroes `faultValid`, `faultAddr` and `faultStatus` after the next edge. This holds even when a faulting access arrives in the same cycle.
- R11: While `rst_n` is 0, all outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset |
| accValid | input | 1 | An access is presented this cycle |
| accAddr | input | 32 | Logical address of this access |
| xferStart | input | 32 | Start address of the whole transfer |
| opwordAddr | input | 32 | Opword address of the current instruction |
| accKind | input | 2 | 00 data, 01 opword, 10 extension word |
| seqIdx | input | 2 | Index of this access within a misaligned transfer |
| accLocked | input | 1 | Access belongs to a processor-initiated locked sequence |
| busLockMode | input | 1 | Software-controlled bus lock mode is active |
| accWrite | input | 1 | 1 for write, 0 for read |
| accSize | input | 2 | Access size code |
| accType | input | 2 | Transfer type code |
| accMod | input | 3 | Transfer modifier code |
| cause | input | 15 | Fault cause vector, nonzero means fault |
| clr | input | 1 | Release the captured fault |
| faultValid | output | 1 | A fault is held |
| faultAddr | output | 32 | Captured fault address |
| faultStatus | output | 32 | Captured fault status word |

## Verification
A clear pulse and a fresh faulting access can land in the same cycle, and clear must win. The bench first captures a fault. It then drives `clr` together with a new faulting access in a single cycle, and requires that `faultValid`, `faultAddr` and `faultStatus` all read zero afterwards. A further fault after the clear must then be captured normally, which shows that the dropped access left no trace.

// File: rtl/fault_capture_pkg.sv
package fault_capture_pkg;
  localparam int STATUS_W = 32;
  localparam int CAUSE_W  = 15;

  typedef enum logic [1:0] {
    KIND_DATA = 2'b00,
    KIND_OPW  = 2'b01,
    KIND_EXT  = 2'b10,
    KIND_RSVD = 2'b11
  } acc_kind_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;
    logic clear;
  } cap_strobe_t;

  // status word field positions
  localparam int POS_INSTR = 27;
  localparam int POS_LATER = 25;
  localparam int POS_LOCK  = 24;
  localparam int POS_WRITE = 23;
  localparam int POS_SIZE  = 21;
  localparam int POS_TYPE  = 19;
  localparam int POS_MOD   = 16;
  localparam int POS_CAUSE_HI = 2;
endpackage

// File: rtl/fault_capture_ctrl.sv
module fault_capture_ctrl
  import fault_capture_pkg::*;
#(
  parameter int CW = CAUSE_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accValid,
  input  logic [CW-1:0] cause,
  input  logic          clr,
  output cap_strobe_t   strobe,
  output logic          validQ
);
  logic faultSeen;

  always_comb begin
    faultSeen      = accValid && (cause != '0);
    strobe.clear   = clr;
    strobe.capture = faultSeen && !validQ && !clr;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              validQ <= 1'b0;
    else if (strobe.clear)   validQ <= 1'b0;
    else if (strobe.capture) validQ <= 1'b1;
  end
endmodule

// File: rtl/fault_capture_dp.sv
module fault_capture_dp
  import fault_capture_pkg::*;
#(
  parameter int AW = 32,
  parameter int SW = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  cap_strobe_t         strobe,
  input  logic [AW-1:0]       accAddr,
  input  logic [AW-1:0]       xferStart,
  input  logic [AW-1:0]       opwordAddr,
  input  logic [1:0]          accKind,
  input  logic [SW-1:0]       seqIdx,
  input  logic                accLocked,
  input  logic                busLockMode,
  input  logic                accWrite,
  input  logic [1:0]          accSize,
  input  logic [1:0]          accType,
  input  logic [2:0]          accMod,
  input  logic [CAUSE_W-1:0]  cause,
  output logic [AW-1:0]       addrQ,
  output logic [STATUS_W-1:0] statusQ
);
  logic                isInstr, isLater;
  logic [AW-1:0]       addrNext;
  logic [STATUS_W-1:0] statusNext;

  always_comb begin
    isInstr  = 1'b0;
    isLater  = 1'b0;
    addrNext = accAddr;
    unique case (acc_kind_e'(accKind))
      KIND_OPW: begin
        isInstr  = 1'b1;
        addrNext = accAddr;
      end
      KIND_EXT: begin
        isInstr  = 1'b1;
        isLater  = 1'b1;
        addrNext = opwordAddr;
      end
      default: begin
        isLater  = (seqIdx != '0);
        addrNext = isLater ? xferStart : accAddr;
      end
    endcase
  end

  always_comb begin
    statusNext = '0;
    statusNext[POS_INSTR]               = isInstr;
    statusNext[POS_LATER]               = isLater;
    statusNext[POS_LOCK]                = accLocked | busLockMode;
    statusNext[POS_WRITE]               = accWrite;
    statusNext[POS_SIZE +: 2]           = accSize;
    statusNext[POS_TYPE +: 2]           = accType;
    statusNext[POS_MOD +: 3]            = accMod;
    statusNext[POS_CAUSE_HI +: CAUSE_W-1] = cause[CAUSE_W-1:1];
    statusNext[0]                       = cause[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addrQ   <= '0;
      statusQ <= '0;
    end else if (strobe.clear) begin
      addrQ   <= '0;
      statusQ <= '0;
    end else if (strobe.capture) begin
      addrQ   <= addrNext;
      statusQ <= statusNext;
    end
  end
endmodule

// File: rtl/fault_capture_unit.sv
module fault_capture_unit
  import fault_capture_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        accValid,
  input  logic [31:0] accAddr,
  input  logic [31:0] xferStart,
  input  logic [31:0] opwordAddr,
  input  logic [1:0]  accKind,
  input  logic [1:0]  seqIdx,
  input  logic        accLocked,
  input  logic        busLockMode,
  input  logic        accWrite,
  input  logic [1:0]  accSize,
  input  logic [1:0]  accType,
  input  logic [2:0]  accMod,
  input  logic [14:0] cause,
  input  logic        clr,
  output logic        faultValid,
  output logic [31:0] faultAddr,
  output logic [31:0] faultStatus
);
  cap_strobe_t strobe;

  fault_capture_ctrl #(.CW(CAUSE_W)) ctrl_i (
    .clk(clk), .rst_n(rst_n), .accValid(accValid), .cause(cause),
    .clr(clr), .strobe(strobe), .validQ(faultValid)
  );

  fault_capture_dp #(.AW(32), .SW(2)) dp_i (
    .clk(clk), .rst_n(rst_n), .strobe(strobe),
    .accAddr(accAddr), .xferStart(xferStart), .opwordAddr(opwordAddr),
    .accKind(accKind), .seqIdx(seqIdx), .accLocked(accLocked),
    .busLockMode(busLockMode), .accWrite(accWrite), .accSize(accSize),
    .accType(accType), .accMod(accMod), .cause(cause),
    .addrQ(faultAddr), .statusQ(faultStatus)
  );
endmodule

// File: rtl/fault_capture_chk.sv
module fault_capture_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        accValid,
  input logic [31:0] accAddr,
  input logic [1:0]  accKind,
  input logic [1:0]  seqIdx,
  input logic [14:0] cause,
  input logic        clr,
  input logic        faultValid,
  input logic [31:0] faultAddr,
  input logic [31:0] faultStatus
);
  logic newFault;
  assign newFault = accValid && (cause != '0) && !faultValid && !clr;

  a_r1_capture_sets_valid: assert property (@(posedge clk) disable iff (!rst_n)
    newFault |=> faultValid);

  a_r1_no_fault_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
    (!faultValid && !(accValid && cause != '0)) |=> !faultValid);

  a_r2_opword_code: assert property (@(posedge clk) disable iff (!rst_n)
    (newFault && accKind == 2'b01) |=> (faultStatus[27] && !faultStatus[25]));

  a_r3_first_data_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (newFault && accKind == 2'b00 && seqIdx == 2'b00) |=> (faultAddr == $past(accAddr)));

  // R8 reserved bits
  a_r8_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (faultStatus[31:28] == 4'h0) && !faultStatus[26] && !faultStatus[1]);

  a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (faultValid && !clr) |=> ($stable(faultAddr) && $stable(faultStatus) && faultValid));

  a_r10_clear_wins: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (!faultValid && faultAddr == '0 && faultStatus == '0));
endmodule

bind fault_capture_unit fault_capture_chk chk_i (
  .clk(clk), .rst_n(rst_n), .accValid(accValid), .accAddr(accAddr),
  .accKind(accKind), .seqIdx(seqIdx), .cause(cause), .clr(clr),
  .faultValid(faultValid), .faultAddr(faultAddr), .faultStatus(faultStatus)
);

// File: tb/fault_capture_unit_tb_top.sv
`timescale 1ns/1ps
module fault_capture_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        accValid = 1'b0;
  logic [31:0] accAddr = '0, xferStart = '0, opwordAddr = '0;
  logic [1:0]  accKind = '0, seqIdx = '0;
  logic        accLocked = 1'b0, busLockMode = 1'b0, accWrite = 1'b0;
  logic [1:0]  accSize = '0, accType = '0;
  logic [2:0]  accMod = '0;
  logic [14:0] cause = '0;
  logic        clr = 1'b0;
  logic        faultValid;
  logic [31:0] faultAddr, faultStatus;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fault_capture_unit dut_i (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] expStatus(input logic [1:0] kind, input logic [1:0] seq,
      input logic lk, input logic wr, input logic [1:0] sz, input logic [1:0] tt,
      input logic [2:0] tm, input logic [14:0] cs);
    logic [31:0] s = '0;
    logic instr = (kind == 2'b01) || (kind == 2'b10);
    logic later = (kind == 2'b10) || (!instr && seq != 2'b00);
    s[27] = instr; s[25] = later; s[24] = lk; s[23] = wr;
    s[22:21] = sz; s[20:19] = tt; s[18:16] = tm;
    s[15:2] = cs[14:1]; s[0] = cs[0];
    return s;
  endfunction

  // drive one access for one cycle, then sample at the following falling edge
  task automatic access(input logic [1:0] kind, input logic [1:0] seq, input logic [31:0] a,
      input logic [31:0] st, input logic [31:0] op, input logic lk, input logic bl,
      input logic wr, input logic [1:0] sz, input logic [1:0] tt, input logic [2:0] tm,
      input logic [14:0] cs, input logic doClr);
    @(negedge clk);
    accValid = 1'b1; accKind = kind; seqIdx = seq; accAddr = a; xferStart = st;
    opwordAddr = op; accLocked = lk; busLockMode = bl; accWrite = wr;
    accSize = sz; accType = tt; accMod = tm; cause = cs; clr = doClr;
    @(negedge clk);
    accValid = 1'b0; cause = '0; clr = 1'b0; accLocked = 1'b0; busLockMode = 1'b0;
  endtask

  task automatic pulseClear();
    @(negedge clk); clr = 1'b1;
    @(negedge clk); clr = 1'b0;
  endtask

  task automatic tReset();
    check("R11 valid", {31'd0, faultValid}, 32'd0);
    check("R11 addr", faultAddr, 32'd0);
    check("R11 status", faultStatus, 32'd0);
  endtask

  task automatic tDataFirst();
    access(2'b00, 2'b00, 32'h1000_0004, 32'h1000_0004, 32'h0, 0, 0, 0, 2'b10, 2'b01, 3'b101, 15'h0001, 0);
    check("R1 valid set", {31'd0, faultValid}, 32'd1);
    check("R3 seq0 addr", faultAddr, 32'h1000_0004);
    check("R2/R6/R7 status data seq0", faultStatus, expStatus(2'b00, 2'b00, 0, 0, 2'b10, 2'b01, 3'b101, 15'h0001));
    pulseClear();
  endtask

  task automatic tDataLater();
    access(2'b00, 2'b01, 32'h2000_0008, 32'h2000_0005, 32'h0, 0, 0, 1, 2'b11, 2'b00, 3'b001, 15'h0004, 0);
    check("R3 seq1 addr", faultAddr, 32'h2000_0005);
    check("R2 data later code", faultStatus, expStatus(2'b00, 2'b01, 0, 1, 2'b11, 2'b00, 3'b001, 15'h0004));
    pulseClear();
    access(2'b11, 2'b11, 32'h2000_0010, 32'h2000_000D, 32'h0, 0, 0, 0, 2'b00, 2'b00, 3'b000, 15'h4000, 0);
    check("R3 seq3 kind11 addr", faultAddr, 32'h2000_000D);
    check("R2 kind11 as data code", faultStatus, expStatus(2'b00, 2'b11, 0, 0, 2'b00, 2'b00, 3'b000, 15'h4000));
    pulseClear();
  endtask

  task automatic tInstr();
    access(2'b01, 2'b00, 32'h0000_4000, 32'h0, 32'h0000_4000, 0, 0, 0, 2'b01, 2'b10, 3'b110, 15'h0010, 0);
    check("R4 opword addr", faultAddr, 32'h0000_4000);
    check("R2 opword code", faultStatus, expStatus(2'b01, 2'b00, 0, 0, 2'b01, 2'b10, 3'b110, 15'h0010));
    pulseClear();
    access(2'b10, 2'b00, 32'h0000_4002, 32'h0, 32'h0000_4000, 0, 0, 0, 2'b01, 2'b10, 3'b110, 15'h0100, 0);
    check("R4 ext word addr", faultAddr, 32'h0000_4000);
    check("R2 ext code", faultStatus, expStatus(2'b10, 2'b00, 0, 0, 2'b01, 2'b10, 3'b110, 15'h0100));
    pulseClear();
  endtask

  task automatic tLockAndCauses();
    access(2'b00, 2'b00, 32'hABCD_0000, 32'hABCD_0000, 32'h0, 1, 0, 1, 2'b00, 2'b11, 3'b011, 15'h7FFF, 0);
    check("R5 locked bit", {31'd0, faultStatus[24]}, 32'd1);
    check("R7 all causes", faultStatus, expStatus(2'b00, 2'b00, 1, 1, 2'b00, 2'b11, 3'b011, 15'h7FFF));
    check("R8 reserved zero", faultStatus & 32'hF400_0002, 32'd0);
    pulseClear();
    access(2'b00, 2'b00, 32'h0000_0040, 32'h0000_0040, 32'h0, 0, 1, 0, 2'b01, 2'b01, 3'b010, 15'h2001, 0);
    check("R5 bus lock mode", faultStatus, expStatus(2'b00, 2'b00, 1, 0, 2'b01, 2'b01, 3'b010, 15'h2001));
    pulseClear();
  endtask

  task automatic tIgnore();
    // accValid low with a cause, and a valid access with no cause: no capture
    @(negedge clk); cause = 15'h0001; accValid = 1'b0;
    @(negedge clk); cause = '0; accValid = 1'b1; accAddr = 32'h5555_0000;
    @(negedge clk); accValid = 1'b0;
    check("R1 nothing captured", {31'd0, faultValid}, 32'd0);
    access(2'b00, 2'b00, 32'h0000_1111, 32'h0000_1111, 32'h0, 0, 0, 0, 2'b00, 2'b00, 3'b000, 15'h0002, 0);
    access(2'b01, 2'b00, 32'h0000_2222, 32'h0, 32'h0000_2222, 1, 0, 1, 2'b11, 2'b11, 3'b111, 15'h7000, 0);
    check("R9 addr held", faultAddr, 32'h0000_1111);
    check("R9 status held", faultStatus, expStatus(2'b00, 2'b00, 0, 0, 2'b00, 2'b00, 3'b000, 15'h0002));
  endtask

  task automatic tClearRace();
    // still holding from tIgnore; clear arrives with a new fault
    access(2'b01, 2'b00, 32'h0000_3333, 32'h0, 32'h0000_3333, 0, 0, 0, 2'b01, 2'b01, 3'b001, 15'h0008, 1);
    check("R10 valid cleared", {31'd0, faultValid}, 32'd0);
    check("R10 addr cleared", faultAddr, 32'd0);
    check("R10 status cleared", faultStatus, 32'd0);
    // clear from empty with fault in same cycle: still nothing
    access(2'b01, 2'b00, 32'h0000_3334, 32'h0, 32'h0000_3334, 0, 0, 0, 2'b01, 2'b01, 3'b001, 15'h0008, 1);
    check("R10 clear beats fresh fault", {31'd0, faultValid}, 32'd0);
    access(2'b00, 2'b10, 32'h0000_6006, 32'h0000_6003, 32'h0, 0, 0, 0, 2'b10, 2'b00, 3'b000, 15'h0020, 0);
    check("R10 capture after clear", faultAddr, 32'h0000_6003);
  endtask

  initial begin
    #1 tReset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tReset();
    tDataFirst();
    tDataLater();
    tInstr();
    tLockAndCauses();
    tIgnore();
    tClearRace();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule